// File: doc/BRIEF.md
# Age-Filtered Redirect Arbiter

This block sits between the execute stage and the rest of an out-of-order pipeline. Each cycle it accepts up to `NUM_REQ` redirect requests (branch mispredicts or other squash requests), each tagged with a thread, the sequence number of the instruction causing it, a corrected target address and a mispredict flag. It picks at most one of them to broadcast to every pipeline stage. The broadcast tells the stages the sequence number up to which they keep instructions, where fetch resumes and whether a predictor mispredict caused it.

For each thread the block holds a bound: the sequence number of the youngest instruction still valid in flight. A new allocation for a thread moves the bound to the allocated instruction. A redirect can win only if it is strictly older than its thread's bound. A redirect at or beyond the bound belongs to an instruction that is already gone, so it is dropped. When a redirect wins, the bound of its thread moves down to the winner's sequence number. Sequence numbers wrap, so all age comparisons use the sign of the modular difference.

Top module: `redir_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `bcast_valid` is 0. Every thread's bound resets to 0, so after reset a request with sequence 0 is dropped and a request with sequence 255 (8-bit) is accepted.
- R2: A request is eligible only if `req_valid` is set and `(req_seq - bound[req_tid])`, taken modulo 2^SEQ_W, has its top bit set. This means it is strictly older than the bound. Equal or younger requests are dropped.
- R3: Among the eligible requests of a cycle, the oldest wins, whatever its thread. When two have equal sequence numbers, the lower port index wins. Request port i occupies slice i of each packed request vector.
- R4: The winner is broadcast one clock after it is presented, as a one-cycle `bcast_valid` pulse. In that same cycle `bcast_tid`, `bcast_seq`, `bcast_target` and `bcast_mispred` carry the winner's fields. A cycle with no eligible request gives `bcast_valid` = 0.
- R5: On a broadcast, the winner thread's bound becomes the winner's sequence number. A repeat of the same redirect is therefore dropped.
- R6: `alloc_valid` sets `bound[alloc_tid]` to `alloc_seq`. If the same thread also has a broadcast in the same cycle, the broadcast's update takes precedence.
- R7: A dropped request, or an eligible one that loses arbitration, produces no broadcast and changes no bound. The bounds of other threads are never touched by a broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | An instruction is allocated this cycle |
| alloc_tid | input | TID_W | Thread of the allocated instruction |
| alloc_seq | input | SEQ_W | Sequence number of the allocated instruction |
| req_valid | input | NUM_REQ | Per-port redirect request valid |
| req_tid | input | NUM_REQ*TID_W | Per-port thread |
| req_seq | input | NUM_REQ*SEQ_W | Per-port sequence number of the redirecting instruction |
| req_target | input | NUM_REQ*ADDR_W | Per-port corrected fetch address |
| req_mispred | input | NUM_REQ | Per-port flag: caused by a branch mispredict |
| bcast_valid | output | 1 | One-cycle broadcast pulse |
| bcast_tid | output | TID_W | Thread being redirected |
| bcast_seq | output | SEQ_W | Squash-until sequence number |
| bcast_target | output | ADDR_W | Address fetch resumes from |
| bcast_mispred | output | 1 | Mispredict flag of the winner |

## Verification
The bench builds the block with four threads, two request ports, 8-bit sequence numbers and 32-bit targets. The 8-bit sequence space wraps many times during the random phase, so the modular age comparison is exercised on both sides of the wrap point. Four threads against two ports make same-cycle contention between different threads frequent, and it also happens that one port is older but ineligible while the other port wins. Directed cases cover equal-sequence ties, repeats of an accepted redirect, and an allocation that coincides with a broadcast on the same thread.

// File: rtl/redir_pkg.sv
// Package: shared age arithmetic for the redirect arbiter.
// Assumes sequence numbers no wider than 32 bits and in-flight spans under half the space.
package redir_pkg;

    // True when sequence a is strictly older than b in a w-bit wrapping space.
    function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/redir_bound_regs.sv
// Per-thread youngest-valid bound registers.
// Assumes at most one allocation and one broadcast update per cycle; the update wins on a clash.
module redir_bound_regs #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int TID_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [TID_W-1:0]             alloc_tid,
    input  logic [SEQ_W-1:0]             alloc_seq,
    input  logic                         upd_valid,
    input  logic [TID_W-1:0]             upd_tid,
    input  logic [SEQ_W-1:0]             upd_seq,
    output logic [NUM_THREADS*SEQ_W-1:0] bound_flat
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic [SEQ_W-1:0] bound_q;
        logic             hit_upd;
        logic             hit_alloc;

        // Decode whether this thread is the target of either write source.
        always_comb begin
            hit_upd   = upd_valid   && (32'(upd_tid)   == t);
            hit_alloc = alloc_valid && (32'(alloc_tid) == t);
        end

        // Hold the bound; a broadcast update has priority over an allocation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bound_q <= '0;
            end else if (hit_upd) begin
                bound_q <= upd_seq;
            end else if (hit_alloc) begin
                bound_q <= alloc_seq;
            end
        end

        assign bound_flat[t*SEQ_W +: SEQ_W] = bound_q;
    end

endmodule

// File: rtl/redir_filter.sv
// Marks each request port eligible when it is valid, names a real thread,
// and is strictly older than that thread's bound. Purely combinational.
module redir_filter #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int TID_W       = 2,
    parameter int NUM_REQ     = 2
) (
    input  logic [NUM_REQ-1:0]           req_valid,
    input  logic [NUM_REQ*TID_W-1:0]     req_tid,
    input  logic [NUM_REQ*SEQ_W-1:0]     req_seq,
    input  logic [NUM_THREADS*SEQ_W-1:0] bound_flat,
    output logic [NUM_REQ-1:0]           eligible
);
    import redir_pkg::*;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_port
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [SEQ_W-1:0] bnd;
        logic             tid_ok;

        assign tid = req_tid[i*TID_W +: TID_W];
        assign seq = req_seq[i*SEQ_W +: SEQ_W];

        // Look up the bound of the requesting thread and compare ages.
        always_comb begin
            tid_ok = 32'(tid) < NUM_THREADS;
            bnd    = tid_ok ? bound_flat[32'(tid)*SEQ_W +: SEQ_W] : '0;
            eligible[i] = req_valid[i] && tid_ok &&
                          seq_older(32'(seq), 32'(bnd), SEQ_W);
        end
    end

endmodule

// File: rtl/redir_pick.sv
// Selects the oldest eligible request; equal ages resolve to the lower port.
// Assumes the eligible ports span less than half the sequence space.
module redir_pick #(
    parameter int SEQ_W   = 8,
    parameter int NUM_REQ = 2,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0]       eligible,
    input  logic [NUM_REQ*SEQ_W-1:0] req_seq,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx
);
    import redir_pkg::*;

    logic [SEQ_W-1:0] best_seq;

    // Scan ports in order, replacing the current best only with a strictly older one.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        best_seq = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (eligible[i] &&
                (!found || seq_older(32'(req_seq[i*SEQ_W +: SEQ_W]), 32'(best_seq), SEQ_W))) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                best_seq = req_seq[i*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/redir_arbiter.sv
// Top: filters redirect requests against per-thread bounds, picks the oldest,
// registers it as a one-cycle broadcast and lowers that thread's bound.
// Assumes synchronous active-low reset and inputs stable around the clock edge.
module redir_arbiter #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int ADDR_W      = 32,
    parameter int NUM_REQ     = 2,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [TID_W-1:0]          alloc_tid,
    input  logic [SEQ_W-1:0]          alloc_seq,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*TID_W-1:0]  req_tid,
    input  logic [NUM_REQ*SEQ_W-1:0]  req_seq,
    input  logic [NUM_REQ*ADDR_W-1:0] req_target,
    input  logic [NUM_REQ-1:0]        req_mispred,
    output logic                      bcast_valid,
    output logic [TID_W-1:0]          bcast_tid,
    output logic [SEQ_W-1:0]          bcast_seq,
    output logic [ADDR_W-1:0]         bcast_target,
    output logic                      bcast_mispred
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [NUM_THREADS*SEQ_W-1:0] bound_flat;
    logic [NUM_REQ-1:0]           eligible;
    logic                         found;
    logic [IDX_W-1:0]             win_idx;
    logic [TID_W-1:0]             win_tid;
    logic [SEQ_W-1:0]             win_seq;
    logic [ADDR_W-1:0]            win_target;
    logic                         win_mispred;

    redir_bound_regs #(
        .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)
    ) u_bounds (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
        .upd_valid(found), .upd_tid(win_tid), .upd_seq(win_seq),
        .bound_flat(bound_flat)
    );

    redir_filter #(
        .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W), .NUM_REQ(NUM_REQ)
    ) u_filter (
        .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .bound_flat(bound_flat), .eligible(eligible)
    );

    redir_pick #(
        .SEQ_W(SEQ_W), .NUM_REQ(NUM_REQ)
    ) u_pick (
        .eligible(eligible), .req_seq(req_seq), .found(found), .win_idx(win_idx)
    );

    // Gather the winning port's fields.
    always_comb begin
        win_tid     = req_tid[32'(win_idx)*TID_W +: TID_W];
        win_seq     = req_seq[32'(win_idx)*SEQ_W +: SEQ_W];
        win_target  = req_target[32'(win_idx)*ADDR_W +: ADDR_W];
        win_mispred = req_mispred[win_idx];
    end

    // Register the broadcast; the payload loads only with a winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcast_valid   <= 1'b0;
            bcast_tid     <= '0;
            bcast_seq     <= '0;
            bcast_target  <= '0;
            bcast_mispred <= 1'b0;
        end else begin
            bcast_valid <= found;
            if (found) begin
                bcast_tid     <= win_tid;
                bcast_seq     <= win_seq;
                bcast_target  <= win_target;
                bcast_mispred <= win_mispred;
            end
        end
    end

endmodule

// File: rtl/redir_arbiter_checker.sv
// Checker bound into the arbiter: relates requests, broadcasts and bounds over time.
module redir_arbiter_checker #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int NUM_REQ     = 2,
    parameter int TID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         alloc_valid,
    input logic [TID_W-1:0]             alloc_tid,
    input logic [SEQ_W-1:0]             alloc_seq,
    input logic [NUM_REQ-1:0]           req_valid,
    input logic                         bcast_valid,
    input logic [TID_W-1:0]             bcast_tid,
    input logic [SEQ_W-1:0]             bcast_seq,
    input logic [NUM_THREADS*SEQ_W-1:0] bound_flat
);
    import redir_pkg::*;

    logic [NUM_THREADS*SEQ_W-1:0] prev_bound;
    logic                         alloc_v_q;
    logic [TID_W-1:0]             alloc_t_q;
    logic [SEQ_W-1:0]             alloc_s_q;
    logic [SEQ_W-1:0]             cur_b;
    logic [SEQ_W-1:0]             prev_b;
    logic [SEQ_W-1:0]             alloc_b;

    // Keep one-cycle-old copies of the bounds and the allocation.
    always_ff @(posedge clk) begin
        prev_bound <= bound_flat;
        alloc_v_q  <= rst_n && alloc_valid;
        alloc_t_q  <= alloc_tid;
        alloc_s_q  <= alloc_seq;
    end

    // Slice out the bounds the properties talk about.
    always_comb begin
        cur_b   = bound_flat[32'(bcast_tid)*SEQ_W +: SEQ_W];
        prev_b  = prev_bound[32'(bcast_tid)*SEQ_W +: SEQ_W];
        alloc_b = bound_flat[32'(alloc_t_q)*SEQ_W +: SEQ_W];
    end

    assert_no_bcast_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid) |=> !bcast_valid);

    assert_winner_older_than_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> seq_older(32'(bcast_seq), 32'(prev_b), SEQ_W));

    assert_bound_lowered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> cur_b == bcast_seq);

    assert_alloc_sets_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_v_q && !(bcast_valid && bcast_tid == alloc_t_q)) |-> alloc_b == alloc_s_q);

    assert_bounds_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_v_q && !bcast_valid) |-> bound_flat == prev_bound);

endmodule

bind redir_arbiter redir_arbiter_checker #(
    .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .NUM_REQ(NUM_REQ), .TID_W(TID_W)
) u_checker (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
    .req_valid(req_valid),
    .bcast_valid(bcast_valid), .bcast_tid(bcast_tid), .bcast_seq(bcast_seq),
    .bound_flat(bound_flat)
);

// File: tb/redir_arbiter_bench.sv
module redir_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int SW = 8;
    localparam int AW = 32;
    localparam int NR = 2;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [TW-1:0] alloc_tid = '0;
    logic [SW-1:0] alloc_seq = '0;
    logic          s_rv [NR];
    logic [TW-1:0] s_rt [NR];
    logic [SW-1:0] s_rs [NR];
    logic [AW-1:0] s_tg [NR];
    logic          s_mp [NR];
    logic [NR-1:0]    req_valid;
    logic [NR*TW-1:0] req_tid;
    logic [NR*SW-1:0] req_seq;
    logic [NR*AW-1:0] req_target;
    logic [NR-1:0]    req_mispred;
    logic          bcast_valid;
    logic [TW-1:0] bcast_tid;
    logic [SW-1:0] bcast_seq;
    logic [AW-1:0] bcast_target;
    logic          bcast_mispred;

    int checks = 0;
    int errors = 0;
    logic [SW-1:0] mb [NT];
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack per-port stimulus into the flat port vectors.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            req_valid[i]               = s_rv[i];
            req_tid[i*TW +: TW]        = s_rt[i];
            req_seq[i*SW +: SW]        = s_rs[i];
            req_target[i*AW +: AW]     = s_tg[i];
            req_mispred[i]             = s_mp[i];
        end
    end

    redir_arbiter #(.NUM_THREADS(NT), .SEQ_W(SW), .ADDR_W(AW), .NUM_REQ(NR)) u_redir_arbiter (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
        .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .req_target(req_target), .req_mispred(req_mispred),
        .bcast_valid(bcast_valid), .bcast_tid(bcast_tid), .bcast_seq(bcast_seq),
        .bcast_target(bcast_target), .bcast_mispred(bcast_mispred)
    );

    function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic [SW-1:0] d;
        d = a - b;
        return d[SW-1];
    endfunction

    task automatic check(input string req, input logic ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_valid = 1'b0;
        for (int i = 0; i < NR; i++) begin
            s_rv[i] = 1'b0; s_rt[i] = '0; s_rs[i] = '0; s_tg[i] = '0; s_mp[i] = 1'b0;
        end
    endtask

    // Apply the stimulus already set up, predict, clock once, compare.
    task automatic step(input string req);
        int win;
        logic [SW-1:0] wseq;
        win = -1;
        wseq = '0;
        for (int i = 0; i < NR; i++) begin
            if (s_rv[i] && older(s_rs[i], mb[s_rt[i]]) &&
                (win < 0 || older(s_rs[i], wseq))) begin
                win = i;
                wseq = s_rs[i];
            end
        end
        if (alloc_valid) mb[alloc_tid] = alloc_seq;
        if (win >= 0) mb[s_rt[win]] = s_rs[win];
        @(posedge clk);
        @(negedge clk);
        check(req, bcast_valid == (win >= 0),
              $sformatf("valid=%0b", bcast_valid), $sformatf("valid=%0b", win >= 0));
        if (win >= 0) begin
            check(req, bcast_tid == s_rt[win] && bcast_seq == s_rs[win] &&
                       bcast_target == s_tg[win] && bcast_mispred == s_mp[win],
                  $sformatf("t%0d s%0d a%h m%0b", bcast_tid, bcast_seq, bcast_target, bcast_mispred),
                  $sformatf("t%0d s%0d a%h m%0b", s_rt[win], s_rs[win], s_tg[win], s_mp[win]));
        end
        clear_inputs();
    endtask

    task automatic set_req(input int p, input int t, input int s, input logic [AW-1:0] a, input logic m);
        s_rv[p] = 1'b1; s_rt[p] = TW'(t); s_rs[p] = SW'(s); s_tg[p] = a; s_mp[p] = m;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        clear_inputs();
        for (int t = 0; t < NT; t++) mb[t] = '0;
        repeat (3) @(negedge clk);
        // R1: no broadcast during reset even with a request present.
        set_req(0, 0, 255, 32'h1000, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R1", bcast_valid == 1'b0, $sformatf("%0b", bcast_valid), "0");
        clear_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", bcast_valid == 1'b0, $sformatf("%0b", bcast_valid), "0");

        // R1/R2: sequence equal to the reset bound is dropped.
        set_req(0, 0, 0, 32'h2000, 1'b0); step("R1_R2_equal_dropped");
        // R1/R2: 255 is older than 0 across the wrap.
        set_req(1, 0, 255, 32'h2004, 1'b1); step("R2_wrap_accepted");
        // R5: repeat of the accepted redirect is dropped.
        set_req(0, 0, 255, 32'h2008, 1'b1); step("R5_repeat_dropped");
        // R3: cross-thread contention, port 1 older wins.
        set_req(0, 1, 250, 32'h3000, 1'b0); set_req(1, 2, 248, 32'h3004, 1'b1); step("R3_older_wins");
        // R7: thread 1 bound untouched by the loser, so 250 is accepted now.
        set_req(0, 1, 250, 32'h3008, 1'b1); step("R7_loser_no_change");
        // R3: equal sequence numbers, lower port wins.
        set_req(0, 3, 200, 32'h4000, 1'b0); set_req(1, 0, 200, 32'h4004, 1'b1); step("R3_tie_low_port");
        // R6: allocation and broadcast on the same thread, broadcast wins.
        alloc_valid = 1'b1; alloc_tid = 2'd3; alloc_seq = 8'd10;
        set_req(0, 3, 190, 32'h5000, 1'b1); step("R6_update_priority");
        set_req(1, 3, 195, 32'h5004, 1'b0); step("R6_bound_is_190");
        // R6: allocation alone raises the bound.
        alloc_valid = 1'b1; alloc_tid = 2'd1; alloc_seq = 8'd100; step("R6_alloc");
        set_req(0, 1, 99, 32'h6000, 1'b0); step("R6_after_alloc");
        // R4: idle cycle produces no pulse.
        step("R4_idle");

        // Random phase: allocations advance bounds, requests straddle them.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) != 0) begin
                alloc_valid = 1'b1;
                alloc_tid = TW'($urandom_range(0, NT-1));
                alloc_seq = mb[alloc_tid] + SW'($urandom_range(1, 6));
            end
            for (int p = 0; p < NR; p++) begin
                if ($urandom_range(0, 1) != 0) begin
                    int t;
                    t = $urandom_range(0, NT-1);
                    set_req(p, t, int'(mb[t]) - $urandom_range(0, 12) + $urandom_range(0, 3),
                            $urandom, 1'($urandom_range(0, 1)));
                end
            end
            step("R2_R3_R4_R5_R6_R7_random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule